// File: doc/BRIEF.md
# Headphone Path Mode and Gain Controller

This block holds the two control registers of a stereo headphone output path and turns them into the enable, routing, mute and gain signals that the analog side uses. A serial-bus slave hands it one write at a time as a byte strobe. Bit 7 of the byte selects the target register, and the low seven bits are the new contents of that register. The block keeps no other state.

The mode register holds the per-channel shutdown and mute bits, a bias shutdown bit and a charge-pump-only bit. The volume register holds a global shutdown bit and a 6-bit volume code.

The shutdown requests are resolved in a fixed order:
1. Global shutdown turns everything off.
2. Charge-pump-only mode keeps only the charge pump running.
3. The per-channel shutdowns come last. Shutting down only the right channel folds both inputs into the left output.

The volume code maps through a three-segment curve, with a separate floor value at code 0, to a signed gain in half-dB units. All outputs are registered. They take their new values at the same clock edge that samples the write strobe, so they are valid during the following cycle.

Top module: `hpamp_ctrl`

## Requirements
- R1: When `wr_valid` is high at a rising edge, bit 7 of `wr_byte` selects the register (0 = mode, 1 = volume) and bits 6..0 are written to it. All outputs show the result in the cycle after that edge. While `wr_valid` is low, no output changes, whatever `wr_byte` carries.
- R2: After reset, the mode register is 0 and the volume register holds global shutdown = 1 with code 0. All enables, the mono select and both mutes are therefore 0, and the gain is -192.
- R3: Volume bit 6 (global shutdown) = 1 turns off the charge pump, the bias, both amplifiers and the mono select, whatever the mode register holds.
- R4: Mode bit 4 (charge-pump-only) = 1, with global shutdown clear, keeps the charge pump on. It turns off both amplifiers, the bias and the mono select, whatever the channel shutdown bits hold.
- R5: Mode bit 1 (right shutdown) = 1 with mode bit 6 = 0, in normal operation, turns off the right amplifier, keeps the left amplifier on and raises the mono-to-left select.
- R6: Mode bit 6 (left shutdown) = 1 with bit 1 = 0 turns off only the left amplifier, with no mono select. With both bits set, both amplifiers are off and the charge pump stays on.
- R7: In normal operation, mode bit 5 = 1 turns the bias off and mode bit 5 = 0 turns it on.
- R8: Mode bit 2 drives the left mute and mode bit 0 drives the right mute. Neither bit changes any enable.
- R9: Volume code 0 gives a gain of -192. Codes 1 to 9 give -120 plus 6 for each step above code 1.
- R10: Codes 9 to 22 rise in steps of 3 from -72 to -33. Codes 23 to 63 rise in steps of 1 from -32 to +8.
- R11: Mode bit 3 is reserved. Writing it as 1 changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write strobe from the bus slave |
| wr_byte | input | 8 | Bit 7 selects the register, bits 6..0 are the payload |
| amp_l_en | output | 1 | Left amplifier enable |
| amp_r_en | output | 1 | Right amplifier enable |
| cp_en | output | 1 | Charge pump enable |
| bias_en | output | 1 | Bias generator enable |
| mono_to_left | output | 1 | Sum both inputs into the left output |
| mute_l | output | 1 | Left channel mute |
| mute_r | output | 1 | Right channel mute |
| gain_hdb | output | 9 | Signed channel gain in half-dB units |

## Verification
The decoded outputs are registered copies of a function of the two stored registers. A wrong stored bit or a wrong priority is therefore visible at the ports in the cycle right after the write that caused it, and it stays visible until the next write. The bench checks every cycle, idle cycles included, so a spurious update with the strobe low also shows at once. All 64 volume codes are swept, so an off-by-one at a segment break shows up as a wrong gain on that one code.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
  localparam int PAYLOAD_W = 7;
  localparam int BYTE_W    = PAYLOAD_W + 1;
  localparam int CODE_W    = 6;
  localparam int GAIN_W    = 9;

  typedef struct packed {
    logic sd_left;
    logic bias_off;
    logic pump_only;
    logic rsv;
    logic mute_left;
    logic sd_right;
    logic mute_right;
  } mode_t;

  typedef struct packed {
    logic              sd_all;
    logic [CODE_W-1:0] code;
  } vol_t;

  typedef struct packed {
    logic amp_l;
    logic amp_r;
    logic pump;
    logic bias;
    logic mono;
    logic mute_l;
    logic mute_r;
  } ctl_t;
endpackage

// File: rtl/hpc_regs.sv
module hpc_regs
  import hpc_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [BW-1:0] wr_byte,
  output mode_t         mode_nxt,
  output vol_t          vol_nxt,
  output mode_t         mode_q,
  output vol_t          vol_q
);
  localparam int SEL_BIT = BW - 1;

  logic  hit_mode;
  logic  hit_vol;
  mode_t mode_in;

  assign hit_mode = wr_valid && !wr_byte[SEL_BIT];
  assign hit_vol  = wr_valid &&  wr_byte[SEL_BIT];

  // The reserved bit is never stored.
  always_comb begin
    mode_in     = mode_t'(wr_byte[SEL_BIT-1:0]);
    mode_in.rsv = 1'b0;
  end

  assign mode_nxt = hit_mode ? mode_in : mode_q;
  assign vol_nxt  = hit_vol ? vol_t'(wr_byte[SEL_BIT-1:0]) : vol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= '0;
      vol_q       <= '0;
      vol_q.sd_all <= 1'b1;
    end else begin
      mode_q <= mode_nxt;
      vol_q  <= vol_nxt;
    end
  end
endmodule

// File: rtl/hpc_power_dec.sv
module hpc_power_dec
  import hpc_pkg::*;
#(
  parameter int NCH = 2
) (
  input  mode_t mode,
  input  vol_t  vol,
  output ctl_t  ctl
);
  logic           path_live;
  logic [NCH-1:0] ch_sd;
  logic [NCH-1:0] ch_mute;
  logic [NCH-1:0] ch_en;
  logic           unused_rsv;

  assign unused_rsv = mode.rsv;
  // Priority: global shutdown, then pump-only, then per-channel shutdowns.
  assign path_live  = !vol.sd_all && !mode.pump_only;

  // Channel 0 = left, channel 1 = right.
  assign ch_sd   = {mode.sd_right, mode.sd_left};
  assign ch_mute = {mode.mute_right, mode.mute_left};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ch_en[c] = path_live && !ch_sd[c];
  end

  always_comb begin
    ctl        = '0;
    ctl.amp_l  = ch_en[0];
    ctl.amp_r  = ch_en[1];
    ctl.pump   = !vol.sd_all;
    ctl.bias   = path_live && !mode.bias_off;
    ctl.mono   = path_live && mode.sd_right && !mode.sd_left;
    ctl.mute_l = ch_mute[0];
    ctl.mute_r = ch_mute[1];
  end
endmodule

// File: rtl/hpc_gain_map.sv
module hpc_gain_map #(
  parameter int CW        = 6,
  parameter int GW        = 9,
  parameter int FLOOR_HDB = -192,
  parameter int BASE_HDB  = -120,
  parameter int SEG1_END  = 9,
  parameter int SEG2_END  = 22,
  parameter int STEP1     = 6,
  parameter int STEP2     = 3,
  parameter int STEP3     = 1
) (
  input  logic [CW-1:0] code,
  output logic [GW-1:0] gain
);
  localparam int SEG1_TOP = BASE_HDB + STEP1 * (SEG1_END - 1);
  localparam int SEG2_TOP = SEG1_TOP + STEP2 * (SEG2_END - SEG1_END);

  int c;
  int g;

  always_comb begin
    c = int'(code);
    if (c == 0)
      g = FLOOR_HDB;
    else if (c <= SEG1_END)
      g = BASE_HDB + STEP1 * (c - 1);
    else if (c <= SEG2_END)
      g = SEG1_TOP + STEP2 * (c - SEG1_END);
    else
      g = SEG2_TOP + STEP3 * (c - SEG2_END);
    gain = g[GW-1:0];
  end
endmodule

// File: rtl/hpamp_ctrl.sv
module hpamp_ctrl
  import hpc_pkg::*;
#(
  parameter int GW        = GAIN_W,
  parameter int FLOOR_HDB = -192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic              amp_l_en,
  output logic              amp_r_en,
  output logic              cp_en,
  output logic              bias_en,
  output logic              mono_to_left,
  output logic              mute_l,
  output logic              mute_r,
  output logic [GW-1:0]     gain_hdb
);
  mode_t         mode_nxt, mode_q;
  vol_t          vol_nxt, vol_q;
  ctl_t          ctl_nxt, ctl_q;
  logic [GW-1:0] gain_nxt, gain_q;

  hpc_regs #(.BW(BYTE_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_byte  (wr_byte),
    .mode_nxt (mode_nxt),
    .vol_nxt  (vol_nxt),
    .mode_q   (mode_q),
    .vol_q    (vol_q)
  );

  hpc_power_dec #(.NCH(2)) u_dec (
    .mode (mode_nxt),
    .vol  (vol_nxt),
    .ctl  (ctl_nxt)
  );

  hpc_gain_map #(.CW(CODE_W), .GW(GW), .FLOOR_HDB(FLOOR_HDB)) u_gain (
    .code (vol_nxt.code),
    .gain (gain_nxt)
  );

  // The decode works on the next register values, so outputs move with the registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      gain_q <= FLOOR_HDB[GW-1:0];
    end else begin
      ctl_q  <= ctl_nxt;
      gain_q <= gain_nxt;
    end
  end

  assign amp_l_en     = ctl_q.amp_l;
  assign amp_r_en     = ctl_q.amp_r;
  assign cp_en        = ctl_q.pump;
  assign bias_en      = ctl_q.bias;
  assign mono_to_left = ctl_q.mono;
  assign mute_l       = ctl_q.mute_l;
  assign mute_r       = ctl_q.mute_r;
  assign gain_hdb     = gain_q;
endmodule

// File: rtl/hpc_checker.sv
module hpc_checker #(
  parameter int GW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          amp_l_en,
  input logic          amp_r_en,
  input logic          cp_en,
  input logic          bias_en,
  input logic          mono_to_left,
  input logic          mute_l,
  input logic          mute_r,
  input logic [GW-1:0] gain_hdb,
  input logic          pump_only_q,
  input logic          sd_all_q
);
  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> $stable({amp_l_en, amp_r_en, cp_en, bias_en, mono_to_left, mute_l, mute_r, gain_hdb})); // R1

  AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    sd_all_q |-> !cp_en && !bias_en && !amp_l_en && !amp_r_en && !mono_to_left); // R3

  AST_PUMP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_only_q && !sd_all_q) |-> cp_en && !bias_en && !amp_l_en && !amp_r_en && !mono_to_left); // R4

  AST_MONO_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    mono_to_left |-> amp_l_en && !amp_r_en); // R5

  AST_BIAS_NEEDS_PUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (bias_en || amp_l_en || amp_r_en) |-> cp_en); // R7

  AST_GAIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(gain_hdb) >= -192) && ($signed(gain_hdb) <= 8)); // R10
endmodule

bind hpamp_ctrl hpc_checker #(.GW(GW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_valid     (wr_valid),
  .amp_l_en     (amp_l_en),
  .amp_r_en     (amp_r_en),
  .cp_en        (cp_en),
  .bias_en      (bias_en),
  .mono_to_left (mono_to_left),
  .mute_l       (mute_l),
  .mute_r       (mute_r),
  .gain_hdb     (gain_hdb),
  .pump_only_q  (mode_q.pump_only),
  .sd_all_q     (vol_q.sd_all)
);

// File: tb/sim_hpamp_ctrl.sv
`timescale 1ns/1ps
module sim_hpamp_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_byte = '0;
  logic       amp_l_en, amp_r_en, cp_en, bias_en, mono_to_left, mute_l, mute_r;
  logic [8:0] gain_hdb;

  always #10 clk = ~clk;

  hpamp_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_byte(wr_byte),
    .amp_l_en(amp_l_en), .amp_r_en(amp_r_en), .cp_en(cp_en), .bias_en(bias_en),
    .mono_to_left(mono_to_left), .mute_l(mute_l), .mute_r(mute_r), .gain_hdb(gain_hdb)
  );

  typedef struct {
    logic [6:0] flags;  // amp_l, amp_r, cp, bias, mono, mute_l, mute_r
    int         gain;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_cmp  = 0;
  int   n_bad  = 0;
  logic [6:0] sh_mode = 7'h00;
  logic [6:0] sh_vol  = 7'h40;
  bit   done = 0;

  function automatic int model_gain(input int code);
    int g;
    if (code == 0) return -192;
    g = -120;
    for (int i = 2; i <= code; i++) begin
      if (i <= 9) g += 6;
      else if (i <= 22) g += 3;
      else g += 1;
    end
    return g;
  endfunction

  function automatic logic [6:0] model_flags(input logic [6:0] m, input logic [6:0] v);
    logic al, ar, cp, bi, mo;
    al = 0; ar = 0; cp = 0; bi = 0; mo = 0;
    if (v[6]) begin
      cp = 0;
    end else if (m[4]) begin
      cp = 1;
    end else begin
      cp = 1;
      bi = !m[5];
      case ({m[6], m[1]})
        2'b00: begin al = 1; ar = 1; end
        2'b01: begin al = 1; mo = 1; end
        2'b10: begin ar = 1; end
        default: ;
      endcase
    end
    return {al, ar, cp, bi, mo, m[2], m[0]};
  endfunction

  function automatic exp_t cur(input string tag);
    exp_t e;
    e.flags = model_flags(sh_mode, sh_vol);
    e.gain  = model_gain(int'(sh_vol[5:0]));
    e.tag   = tag;
    return e;
  endfunction

  task automatic wr(input logic [7:0] b, input string tag);
    wr_valid = 1'b1;
    wr_byte  = b;
    if (b[7]) sh_vol = b[6:0]; else sh_mode = b[6:0];
    q.push_back(cur(tag));
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      wr_valid = 1'b0;
      wr_byte  = 8'(8'hA5 ^ (i * 37));
      q.push_back(cur(tag));
      @(negedge clk);
    end
  endtask

  task automatic compare(input exp_t e);
    logic [6:0] act;
    act = {amp_l_en, amp_r_en, cp_en, bias_en, mono_to_left, mute_l, mute_r};
    n_cmp++;
    if (act !== e.flags || int'($signed(gain_hdb)) != e.gain) begin
      n_bad++;
      $display("FAIL %s: flags=%b gain=%0d expected flags=%b gain=%0d",
               e.tag, act, $signed(gain_hdb), e.flags, e.gain);
    end
  endtask

  // Monitor: one expected item per clock, checked after the edge settles.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) compare(q.pop_front());
    end
  end

  initial begin
    exp_t r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    r = cur("R2 reset state");
    compare(r);
    idle(3, "R1 idle after reset");
    wr(8'hB8, "R1 volume write code 56");
    wr(8'h00, "R1 mode all active");
    idle(2, "R1 hold without strobe");
    wr(8'h02, "R5 right shutdown mono");
    wr(8'h40, "R6 left shutdown only");
    wr(8'h42, "R6 both channel shutdown");
    wr(8'h52, "R4 pump only overrides channel bits");
    wr(8'h10, "R4 pump only");
    wr(8'h20, "R7 bias off");
    wr(8'h00, "R7 bias on");
    wr(8'h05, "R8 both mutes");
    wr(8'h44, "R8 left mute with left shutdown");
    wr(8'h15, "R8 mutes in pump only");
    wr(8'h00, "R11 baseline");
    wr(8'h08, "R11 reserved bit written");
    wr(8'h0A, "R11 reserved with right shutdown");
    wr(8'hFF, "R3 global shutdown code 63");
    wr(8'h02, "R3 right shutdown under global off");
    wr(8'h10, "R3 pump only under global off");
    idle(2, "R1 hold in global off");
    wr(8'h00, "R3 mode cleared");
    for (int c = 0; c < 64; c++) begin
      wr(8'h80 | 8'(c), (c <= 9) ? "R9 gain code sweep" : "R10 gain code sweep");
    end
    wr(8'h80 | 8'd22, "R10 segment two top");
    wr(8'h80 | 8'd23, "R10 segment three start");
    idle(2, "R1 hold final");
    while (q.size() > 0) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule